// File: doc/BRIEF.md
# Dual H-Bridge Gate Control and Protection Core

This block is the digital control core for two H-bridges. Each bridge has two logic inputs. One global mode input sets how they are read. In one mode they are two independent half-bridge commands. In the other they are a direction bit and an enable bit. From the decoded command the block drives a high-side and a low-side gate enable for each of the four half-bridge outputs. Each output is therefore driven high, driven low, or left floating with both gates off.

Protection is handled as digital status inputs:
- A per-bridge overcurrent detect, fed from both the high-side and low-side sensing. It shuts the bridge down only after it has stayed asserted past a qualification time. The bridge restarts by itself after a retry interval.
- A thermal input that floats every output while the internal timers keep running.
- An undervoltage input that floats every output and clears all protection state.
- An active-low sleep input that floats everything and holds the protection logic cleared.

A dead-time of a parameterised number of cycles separates any change of an output between high and low. Every input passes through a two-flop synchronizer before it is used.

Top module: `hbridge_ctrl`

## Requirements
- R1: With `mode_i`=0, bridge b decodes {in1_i[b],in2_i[b]} as follows. 00 floats both outputs. 01 drives output1 low and output2 high. 10 drives output1 high and output2 low. 11 drives both low. Output1 of bridge b is gate bit 2b and output2 is bit 2b+1. High means `hs_en_o` bit set; low means `ls_en_o` bit set; floating means neither.
- R2: With `mode_i`=1, in1_i[b] is the direction and in2_i[b] is the enable. Enable 0 drives both outputs low whatever the direction. Enable 1 with direction 0 drives output1 high and output2 low. Enable 1 with direction 1 drives output1 low and output2 high.
- R3: While the synchronized `sleep_n_i` is low, all gate enables are 0 and the overcurrent state is cleared. A bridge tripped before sleep drives again as soon as sleep ends.
- R4: An output moving between high and low spends exactly DEAD_CYC cycles with both gates off. Moving from floating back to the side it last drove is immediate.
- R5: The high-side and low-side enables of one output are never set in the same cycle.
- R6: A bridge's overcurrent detect may come from `ocp_hs_i` or `ocp_ls_i`. Once seen continuously for more than QUAL_CYC synchronized cycles, it turns off all four gates of that bridge and only that bridge. A shorter pulse has no effect.
- R7: A tripped bridge resumes its commanded drive by itself RETRY_CYC cycles after the trip.
- R8: While `therm_i` is set, all gate enables are 0. Overcurrent qualification and retry timing keep running, and drive resumes when `therm_i` clears.
- R9: `uvlo_i` set floats every output and clears any overcurrent trip, so drive resumes as soon as it clears.
- R10: An input change is first visible at the gate outputs after the third rising clock edge: two synchronizer stages plus the output register.
- R11: A change of `mode_i` during operation reinterprets the held inputs with the same latency as any other input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 1 | 0: independent inputs, 1: direction/enable |
| sleep_n_i | input | 1 | Active-low sleep |
| in1_i | input | NB | First control input per bridge (direction in mode 1) |
| in2_i | input | NB | Second control input per bridge (enable in mode 1) |
| ocp_hs_i | input | NB | High-side overcurrent detect per bridge |
| ocp_ls_i | input | NB | Low-side overcurrent detect per bridge |
| therm_i | input | 1 | Over-temperature status |
| uvlo_i | input | 1 | Undervoltage status |
| hs_en_o | output | 2*NB | High-side gate enable per output |
| ls_en_o | output | 2*NB | Low-side gate enable per output |

## Verification
Most faults show up at the gates within a few cycles.
- A wrong decode or synchronizer depth shows as a gate pattern that differs from the reference in the third cycle after the input change.
- A dead-time counter that is off by one shows as a floating gap one cycle too short or too long.
- A wrong qualification or retry counter moves the bridge's drop-out or its return by a counted number of cycles.
- An overcurrent state that survives undervoltage or sleep keeps the bridge floating for up to RETRY_CYC cycles after the override clears.

The bench compares both gate vectors every cycle, so each of these differences is reported in the first cycle it appears.

// File: rtl/hb_pkg.sv
package hb_pkg;

    typedef enum logic [1:0] {
        DRV_OFF = 2'd0,
        DRV_LO  = 2'd1,
        DRV_HI  = 2'd2
    } drv_e;

    typedef struct packed {
        drv_e out1;
        drv_e out2;
    } pair_t;

    typedef enum logic {
        G_RUN  = 1'b0,
        G_WAIT = 1'b1
    } guard_e;

    // Command decode for one bridge; phen selects direction/enable reading.
    function automatic pair_t hb_decode(input logic phen, input logic a, input logic b);
        pair_t p;
        if (phen) begin
            if (!b)     p = '{out1: DRV_LO, out2: DRV_LO};
            else if (a) p = '{out1: DRV_LO, out2: DRV_HI};
            else        p = '{out1: DRV_HI, out2: DRV_LO};
        end else begin
            case ({a, b})
                2'b01:   p = '{out1: DRV_LO,  out2: DRV_HI};
                2'b10:   p = '{out1: DRV_HI,  out2: DRV_LO};
                2'b11:   p = '{out1: DRV_LO,  out2: DRV_LO};
                default: p = '{out1: DRV_OFF, out2: DRV_OFF};
            endcase
        end
        return p;
    endfunction

endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] s1;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '0;
            q  <= '0;
        end else begin
            s1 <= d;
            q  <= s1;
        end
    end
endmodule

// File: rtl/hb_ocp_guard.sv
module hb_ocp_guard
    import hb_pkg::*;
#(
    parameter int QUAL_CYC  = 200000,
    parameter int RETRY_CYC = 200000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic det,
    output logic trip
);
    localparam int QW = $clog2(QUAL_CYC + 1);
    localparam int RW = $clog2(RETRY_CYC);

    guard_e        st;
    logic [QW-1:0] qcnt;
    logic [RW-1:0] rcnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            st   <= G_RUN;
            qcnt <= '0;
            rcnt <= '0;
        end else if (st == G_WAIT) begin
            if (rcnt == RW'(RETRY_CYC - 1)) begin
                st   <= G_RUN;
                qcnt <= '0;
            end else begin
                rcnt <= rcnt + RW'(1);
            end
        end else if (det) begin
            if (qcnt == QW'(QUAL_CYC)) begin
                st   <= G_WAIT;
                rcnt <= '0;
            end else begin
                qcnt <= qcnt + QW'(1);
            end
        end else begin
            qcnt <= '0;
        end
    end

    assign trip = (st == G_WAIT);
endmodule

// File: rtl/hb_half_drive.sv
module hb_half_drive
    import hb_pkg::*;
#(
    parameter int DEAD_CYC = 8
) (
    input  logic clk,
    input  logic rst,
    input  drv_e req,
    output logic hs_o,
    output logic ls_o
);
    localparam int DW = $clog2(DEAD_CYC + 1);

    drv_e          cur, last_on, nxt;
    logic [DW-1:0] off_cnt;

    always_comb begin
        if (req == DRV_OFF)                                      nxt = DRV_OFF;
        else if (cur == req)                                     nxt = req;
        else if (cur != DRV_OFF)                                 nxt = DRV_OFF;
        else if (req == last_on || off_cnt == DW'(DEAD_CYC))     nxt = req;
        else                                                     nxt = DRV_OFF;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur     <= DRV_OFF;
            last_on <= DRV_LO;
            off_cnt <= DW'(DEAD_CYC);
        end else begin
            cur <= nxt;
            if (nxt == DRV_OFF) begin
                if (cur != DRV_OFF)                  off_cnt <= DW'(1);
                else if (off_cnt != DW'(DEAD_CYC))   off_cnt <= off_cnt + DW'(1);
            end else begin
                last_on <= nxt;
            end
        end
    end

    assign hs_o = (cur == DRV_HI);
    assign ls_o = (cur == DRV_LO);
endmodule

// File: rtl/hbridge_ctrl.sv
module hbridge_ctrl
    import hb_pkg::*;
#(
    parameter int NB        = 2,
    parameter int DEAD_CYC  = 8,
    parameter int QUAL_CYC  = 200000,
    parameter int RETRY_CYC = 200000
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            mode_i,
    input  logic            sleep_n_i,
    input  logic [NB-1:0]   in1_i,
    input  logic [NB-1:0]   in2_i,
    input  logic [NB-1:0]   ocp_hs_i,
    input  logic [NB-1:0]   ocp_ls_i,
    input  logic            therm_i,
    input  logic            uvlo_i,
    output logic [2*NB-1:0] hs_en_o,
    output logic [2*NB-1:0] ls_en_o
);
    localparam int SW = 4 * NB + 4;

    logic [SW-1:0] raw_v, syn_v;
    logic [NB-1:0] in1_s, in2_s, ohs_s, ols_s, trip_w;
    logic          mode_s, sleep_s, therm_s, uvlo_s, clr_s;

    assign raw_v = {uvlo_i, therm_i, sleep_n_i, mode_i, ocp_ls_i, ocp_hs_i, in2_i, in1_i};

    hb_sync #(.W(SW)) u_sync (.clk(clk), .rst(rst), .d(raw_v), .q(syn_v));

    assign {uvlo_s, therm_s, sleep_s, mode_s, ols_s, ohs_s, in2_s, in1_s} = syn_v;
    assign clr_s = !sleep_s || uvlo_s;

    for (genvar b = 0; b < NB; b++) begin : g_br
        pair_t cmd;
        drv_e  req1, req2;
        logic  blk;

        hb_ocp_guard #(.QUAL_CYC(QUAL_CYC), .RETRY_CYC(RETRY_CYC)) u_guard (
            .clk (clk),
            .rst (rst),
            .clr (clr_s),
            .det (ohs_s[b] || ols_s[b]),
            .trip(trip_w[b])
        );

        always_comb begin
            cmd  = hb_decode(mode_s, in1_s[b], in2_s[b]);
            blk  = clr_s || therm_s || trip_w[b];
            req1 = blk ? DRV_OFF : cmd.out1;
            req2 = blk ? DRV_OFF : cmd.out2;
        end

        hb_half_drive #(.DEAD_CYC(DEAD_CYC)) u_o1 (
            .clk(clk), .rst(rst), .req(req1),
            .hs_o(hs_en_o[2*b]), .ls_o(ls_en_o[2*b])
        );
        hb_half_drive #(.DEAD_CYC(DEAD_CYC)) u_o2 (
            .clk(clk), .rst(rst), .req(req2),
            .hs_o(hs_en_o[2*b+1]), .ls_o(ls_en_o[2*b+1])
        );
    end
endmodule

// File: rtl/hbridge_ctrl_chk.sv
module hbridge_ctrl_chk #(
    parameter int NB = 2
) (
    input logic            clk,
    input logic            rst,
    input logic [2*NB-1:0] hs,
    input logic [2*NB-1:0] ls,
    input logic            sleep_s,
    input logic            therm_s,
    input logic            uvlo_s,
    input logic [NB-1:0]   trip
);
    // R5
    no_shoot_through_chk: assert property (@(posedge clk) disable iff (rst)
        (hs & ls) == '0);

    // R3
    sleep_float_chk: assert property (@(posedge clk) disable iff (rst)
        !sleep_s |=> (hs == '0 && ls == '0));

    // R8
    therm_float_chk: assert property (@(posedge clk) disable iff (rst)
        therm_s |=> (hs == '0 && ls == '0));

    // R9
    uvlo_float_chk: assert property (@(posedge clk) disable iff (rst)
        uvlo_s |=> (hs == '0 && ls == '0));

    for (genvar i = 0; i < 2 * NB; i++) begin : g_out
        // R4
        hi_to_lo_gap_chk: assert property (@(posedge clk) disable iff (rst)
            ls[i] |-> !$past(hs[i]));
        // R4
        lo_to_hi_gap_chk: assert property (@(posedge clk) disable iff (rst)
            hs[i] |-> !$past(ls[i]));
    end

    for (genvar b = 0; b < NB; b++) begin : g_br
        // R6
        trip_float_chk: assert property (@(posedge clk) disable iff (rst)
            trip[b] |=> (hs[2*b+1 -: 2] == 2'b00 && ls[2*b+1 -: 2] == 2'b00));
    end
endmodule

bind hbridge_ctrl hbridge_ctrl_chk #(.NB(NB)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .hs     (hs_en_o),
    .ls     (ls_en_o),
    .sleep_s(sleep_s),
    .therm_s(therm_s),
    .uvlo_s (uvlo_s),
    .trip   (trip_w)
);

// File: tb/hbridge_ctrl_test.sv
module hbridge_ctrl_test;
    localparam int DEAD  = 3;
    localparam int QUAL  = 6;
    localparam int RETRY = 40;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode = 1'b0, slp_n = 1'b0, therm = 1'b0, uvlo = 1'b0;
    logic [1:0] in1 = '0, in2 = '0, ohs = '0, ols = '0;
    wire  [3:0] hs, ls;

    int    checks = 0, errs = 0, cyc = 0;
    string tag = "R3";

    always #2.5 clk = ~clk;

    hbridge_ctrl #(.NB(2), .DEAD_CYC(DEAD), .QUAL_CYC(QUAL), .RETRY_CYC(RETRY)) uut (
        .clk(clk), .rst(rst), .mode_i(mode), .sleep_n_i(slp_n),
        .in1_i(in1), .in2_i(in2), .ocp_hs_i(ohs), .ocp_ls_i(ols),
        .therm_i(therm), .uvlo_i(uvlo), .hs_en_o(hs), .ls_en_o(ls)
    );

    // Reference model: 0 float, 1 low, 2 high
    logic [11:0] d1, d2;
    int  qc[2], rc[2], cur[4], last[4], oc[4];
    bit  tr[2];
    logic [3:0] ehs, els;

    function automatic int dec(input bit m, input bit a, input bit e, input bit second);
        int o1, o2;
        if (m) begin
            if (!e) begin o1 = 1; o2 = 1; end
            else if (a) begin o1 = 1; o2 = 2; end
            else begin o1 = 2; o2 = 1; end
        end else begin
            o1 = a ? (e ? 1 : 2) : (e ? 1 : 0);
            o2 = a ? 1 : (e ? 2 : 0);
        end
        return second ? o2 : o1;
    endfunction

    always @(posedge clk) begin
        int rq[4];
        bit blk;
        if (rst) begin
            d1 = '0; d2 = '0;
            for (int b = 0; b < 2; b++) begin qc[b] = 0; rc[b] = 0; tr[b] = 0; end
            for (int i = 0; i < 4; i++) begin cur[i] = 0; last[i] = 1; oc[i] = DEAD; end
        end else begin
            for (int b = 0; b < 2; b++) begin
                blk = !d2[9] || d2[10] || d2[11] || tr[b];
                rq[2*b]   = blk ? 0 : dec(d2[8], d2[b], d2[2+b], 1'b0);
                rq[2*b+1] = blk ? 0 : dec(d2[8], d2[b], d2[2+b], 1'b1);
            end
            for (int i = 0; i < 4; i++) begin
                if (rq[i] == 0 || (cur[i] != 0 && cur[i] != rq[i])) begin
                    oc[i] = (cur[i] != 0) ? 1 : ((oc[i] < DEAD) ? oc[i] + 1 : DEAD);
                    cur[i] = 0;
                end else if (cur[i] == 0) begin
                    if (rq[i] == last[i] || oc[i] >= DEAD) begin
                        cur[i] = rq[i]; last[i] = rq[i];
                    end else begin
                        oc[i] = (oc[i] < DEAD) ? oc[i] + 1 : DEAD;
                    end
                end
            end
            for (int b = 0; b < 2; b++) begin
                if (!d2[9] || d2[11]) begin qc[b] = 0; rc[b] = 0; tr[b] = 0; end
                else if (tr[b]) begin
                    if (rc[b] == RETRY - 1) begin tr[b] = 0; qc[b] = 0; end
                    else rc[b]++;
                end else if (d2[4+b] || d2[6+b]) begin
                    if (qc[b] == QUAL) begin tr[b] = 1; rc[b] = 0; end
                    else qc[b]++;
                end else qc[b] = 0;
            end
            d2 = d1;
            d1 = {uvlo, therm, slp_n, mode, ols, ohs, in2, in1};
        end
        for (int i = 0; i < 4; i++) begin
            ehs[i] = (cur[i] == 2);
            els[i] = (cur[i] == 1);
        end
    end

    task automatic summary_end();
        $display("Simulation finished: %0d checks, %0d errors", checks, errs);
        $finish;
    endtask

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            checks++;
            if (hs !== ehs || ls !== els) begin
                errs++;
                $display("FAIL %s per-cycle: hs=%b ls=%b expected hs=%b ls=%b", tag, hs, ls, ehs, els);
            end
            checks++;
            if ((hs & ls) !== 4'b0000) begin  // R5
                errs++;
                $display("FAIL R5 overlap: hs&ls=%b expected 0000", hs & ls);
            end
        end
        if (cyc > 20000) begin
            errs++;
            $display("FAIL watchdog: cycles=%0d expected fewer than 20000", cyc);
            summary_end();
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_out(input string t, input logic [3:0] xh, input logic [3:0] xl);
        checks++;
        if (hs !== xh || ls !== xl) begin
            errs++;
            $display("FAIL %s: hs=%b ls=%b expected hs=%b ls=%b", t, hs, ls, xh, xl);
        end
    endtask

    task automatic trip_pulse(input bit low_side, input int b);
        if (low_side) ols[b] = 1'b1; else ohs[b] = 1'b1;
        wait_n(10);
        ols = '0; ohs = '0;
        wait_n(2);
    endtask

    initial begin
        int gap;
        wait_n(4);
        rst = 1'b0;
        wait_n(1);
        expect_out("R3 reset", 4'b0000, 4'b0000);
        slp_n = 1'b1;
        wait_n(5);

        tag = "R10";
        in1 = 2'b01;
        wait_n(2); expect_out("R10 before third edge", 4'b0000, 4'b0000);
        wait_n(1); expect_out("R10 at third edge", 4'b0001, 4'b0010);

        tag = "R1";
        in1 = 2'b01; in2 = 2'b10;
        wait_n(10); expect_out("R1 fwd/rev", 4'b1001, 4'b0110);

        tag = "R4";
        in1 = 2'b00; in2 = 2'b11;
        gap = 0;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (!hs[0] && !ls[0]) gap++;
        end
        checks++;
        if (gap != DEAD) begin
            errs++;
            $display("FAIL R4 dead gap: got %0d cycles expected %0d", gap, DEAD);
        end

        tag = "R1";
        in1 = 2'b10; in2 = 2'b01;
        wait_n(12); expect_out("R1 rev/fwd", 4'b0110, 4'b1001);
        in1 = 2'b01; in2 = 2'b01;
        wait_n(12); expect_out("R1 brake/coast", 4'b0000, 4'b0011);

        tag = "R11";
        mode = 1'b1;
        wait_n(12); expect_out("R11 mode switch", 4'b0010, 4'b1101);

        tag = "R2";
        in1 = 2'b10; in2 = 2'b11;
        wait_n(12); expect_out("R2 fwd/rev", 4'b1001, 4'b0110);
        in2 = 2'b00;
        wait_n(12); expect_out("R2 brake", 4'b0000, 4'b1111);

        tag = "R6";
        mode = 1'b0; in1 = 2'b11; in2 = 2'b00;
        wait_n(12); expect_out("R1 fwd/fwd", 4'b0101, 4'b1010);
        ohs[0] = 1'b1; wait_n(5); ohs = '0;
        wait_n(10); expect_out("R6 short pulse ignored", 4'b0101, 4'b1010);
        trip_pulse(1'b1, 0);
        expect_out("R6 low-side trip bridge A", 4'b0100, 4'b1000);
        tag = "R7";
        wait_n(20); expect_out("R7 still off in retry", 4'b0100, 4'b1000);
        wait_n(25); expect_out("R7 auto retry", 4'b0101, 4'b1010);
        tag = "R6";
        trip_pulse(1'b0, 1);
        expect_out("R6 high-side trip bridge B", 4'b0001, 4'b0010);
        wait_n(50);

        tag = "R8";
        therm = 1'b1; ohs[0] = 1'b1;
        wait_n(10); ohs = '0;
        expect_out("R8 thermal off", 4'b0000, 4'b0000);
        wait_n(5); therm = 1'b0;
        wait_n(5); expect_out("R8 trip timer ran", 4'b0100, 4'b1000);
        wait_n(35); expect_out("R8 resumed", 4'b0101, 4'b1010);

        tag = "R9";
        trip_pulse(1'b1, 0);
        uvlo = 1'b1;
        wait_n(3); expect_out("R9 uvlo off", 4'b0000, 4'b0000);
        uvlo = 1'b0;
        wait_n(5); expect_out("R9 trip cleared", 4'b0101, 4'b1010);

        tag = "R3";
        trip_pulse(1'b0, 1);
        slp_n = 1'b0;
        wait_n(5); expect_out("R3 sleep off", 4'b0000, 4'b0000);
        slp_n = 1'b1;
        wait_n(5); expect_out("R3 trip cleared by sleep", 4'b0101, 4'b1010);

        wait_n(3);
        summary_end();
    end
endmodule